// File: doc/BRIEF.md
# Memory-Resident Pointer DMA Channel Engine

This block moves single words between sixteen device channels and a shared memory. It keeps no per-channel address registers. Each channel's transfer descriptor sits in two fixed words of low memory: a start word and an end word. The start word carries the direction in its top bit and the current memory address in its remaining bits. When a device holds its request line high, the engine picks one requesting channel and fetches that channel's descriptor. It moves one word in the encoded direction and writes the advanced start word back. It signals end-of-range once the pointer has moved past the end address.

The memory side is a plain request/grant port. The engine holds the request, address, write enable and write data steady until grant. Read data is taken from the memory in the grant cycle. Each device channel has its own input data lane. Data going out to devices uses one shared lane, qualified by a per-channel acknowledge. Software rewrites an exhausted descriptor in memory and then pulses that channel's rearm line.

Top module: `ptr_dma_engine`

## Requirements
- R1: Channel k (0 to 15) keeps its start word at memory word address 16 + 2k and its end word at 17 + 2k, which is octal 020 through 057 in total.
- R2: Bit 15 of the start word selects the direction. A 1 means input: the channel's device lane is written to memory at the current address. A 0 means output: the memory word at the current address is read and presented on dev_wdata.
- R3: Each service is four memory cycles in a fixed order: read the start word, read the end word, move the data word, write the start word back. Each cycle holds mem_req, mem_addr, mem_we and mem_wdata steady until mem_gnt is high, and read data is taken from mem_rdata in the grant cycle.
- R4: The written-back start word keeps bit 15 unchanged and carries the address field (bits 14:0) plus one.
- R5: ack[k] pulses high for exactly one cycle, in the cycle after the data cycle is granted, and at most one ack bit is high at a time. For an output channel, dev_wdata holds the word read from memory while ack is high.
- R6: When several eligible channels request together, the lowest channel number is served first, and each service moves exactly one word.
- R7: After a write-back, if the incremented address field is greater than bits 14:0 of the end word, done[k] pulses for one cycle, in the cycle after the write-back grant.
- R8: After done[k], requests on channel k are ignored, with no memory cycle and no ack, until rearm[k] is pulsed.
- R9: A rearm[k] pulse in the same cycle as the write-back grant that exhausts channel k takes precedence, so channel k stays eligible.
- R10: While rst_n is low, mem_req, ack and done are low, and after reset every channel is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel request, level |
| rearm | input | NCH | Per-channel pulse: descriptor was rewritten |
| dev_rdata | input | NCH*DW | Per-channel device input data, lane k at bits k*DW +: DW |
| ack | output | NCH | Per-channel one-cycle pulse: one word moved |
| done | output | NCH | Per-channel one-cycle end-of-range pulse |
| dev_wdata | output | DW | Word read from memory for an output channel, valid with ack |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | DW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory grant; the cycle completes in this clock |
| mem_rdata | input | DW | Memory read data, valid in the grant cycle |

## Verification
Two events can fall in the same clock: the write-back that exhausts a channel and the software rearm of that channel. The bench provokes this by watching the memory port for the write-back of a chosen channel while grant is forced high. It pulses rearm in exactly that cycle. It then rewrites the descriptor without a further rearm and expects the new request to be served. A second pair of events, a new request arriving while another channel is in service, comes from the random phase. There, random grant gaps and random request arrival cause over-requests to be dropped after end-of-range. Every moved word, written-back start word and end-of-range pulse is compared with a bench model of the descriptors.

// File: rtl/ptr_dma_engine.sv
module ptr_dma_engine #(
  parameter int NCH  = 16,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    rearm,
  input  logic [NCH*DW-1:0] dev_rdata,
  output logic [NCH-1:0]    ack,
  output logic [NCH-1:0]    done,
  output logic [DW-1:0]     dev_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int CW = $clog2(NCH);
  localparam int AF = DW - 1;

  typedef enum logic [2:0] {S_IDLE, S_RDS, S_RDE, S_XFR, S_WB} st_t;

  st_t             state;
  logic [CW-1:0]   ch_q, pick;
  logic [DW-1:0]   start_q;
  logic [AF-1:0]   end_q;
  logic [NCH-1:0]  halted, elig, set_halt;
  logic [AF:0]     next_field;
  logic [DW-1:0]   desc_addr;
  logic            past, dir_in;

  assign elig       = req & ~halted;
  assign dir_in     = start_q[DW-1];
  assign next_field = {1'b0, start_q[AF-1:0]} + 1'b1;
  assign past       = next_field > {1'b0, end_q};
  assign desc_addr  = DW'(BASE) + DW'({ch_q, 1'b0});
  assign set_halt   = (state == S_WB && mem_gnt && past) ? (NCH'(1) << ch_q) : '0;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) pick = CW'(i);
  end

  assign mem_req = (state != S_IDLE);
  assign mem_we  = (state == S_WB) || (state == S_XFR && dir_in);

  always_comb begin
    mem_addr  = desc_addr;
    mem_wdata = {start_q[DW-1], next_field[AF-1:0]};
    case (state)
      S_RDE:   mem_addr = desc_addr + 1'b1;
      S_XFR: begin
        mem_addr  = {1'b0, start_q[AF-1:0]};
        mem_wdata = dev_rdata[ch_q*DW +: DW];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ch_q      <= '0;
      start_q   <= '0;
      end_q     <= '0;
      halted    <= '0;
      ack       <= '0;
      done      <= '0;
      dev_wdata <= '0;
    end else begin
      ack    <= '0;
      done   <= '0;
      halted <= (halted | set_halt) & ~rearm;
      case (state)
        S_IDLE: if (|elig) begin
          ch_q  <= pick;
          state <= S_RDS;
        end
        S_RDS: if (mem_gnt) begin
          start_q <= mem_rdata;
          state   <= S_RDE;
        end
        S_RDE: if (mem_gnt) begin
          end_q <= mem_rdata[AF-1:0];
          state <= S_XFR;
        end
        S_XFR: if (mem_gnt) begin
          ack[ch_q] <= 1'b1;
          if (!dir_in) dev_wdata <= mem_rdata;
          state <= S_WB;
        end
        S_WB: if (mem_gnt) begin
          if (past) done[ch_q] <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_done_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

  assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(state == S_WB && mem_gnt));

  assert_no_ack_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack & halted) == '0);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $past(!rst_n) |-> (!mem_req && ack == '0 && done == '0));
endmodule

// File: tb/ptr_dma_engine_bench.sv
module ptr_dma_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW  = 16;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] req, rearm, rearm_t = '0, rearm_a = '0, ack, done;
  logic [NCH*DW-1:0] dev_rdata;
  logic [DW-1:0] dev_wdata, mem_addr, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_gnt = 0, force_gnt = 0;

  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  bit          exp_wr [256];
  int pending [NCH], moved [NCH], exp_ptr [NCH], exp_end [NCH], asked [NCH], lens [NCH];
  bit exp_dir [NCH], expect_done [NCH], halted_m [NCH], rearm_hit [NCH];
  int n_chk = 0, n_bad = 0, prev_ack = -1, co_ch = -1, cycles = 0;
  bit order_phase = 0, mon_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_dma_engine u_ptr_dma_engine (
    .clk(clk), .rst_n(rst_n), .req(req), .rearm(rearm), .dev_rdata(dev_rdata),
    .ack(ack), .done(done), .dev_wdata(dev_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

  function automatic logic [15:0] data_for(int ch, int k);
    return 16'(ch * 4096 + k * 37 + 5);
  endfunction

  assign rearm     = rearm_t | rearm_a;
  assign mem_rdata = mem[mem_addr[7:0]];
  always_comb for (int i = 0; i < NCH; i++) begin
    req[i] = pending[i] != 0;
    dev_rdata[i*DW +: DW] = data_for(i, moved[i]);
  end

  always @(posedge clk) if (mem_req && mem_we && mem_gnt) mem[mem_addr[7:0]] <= mem_wdata;
  always @(posedge clk) mem_gnt <= #1 (force_gnt || ($urandom % 4 != 0));

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // monitor and reference model
  always @(negedge clk) if (mon_on) begin
    rearm_a = '0;
    for (int c = 0; c < NCH; c++) if (ack[c]) begin
      check(!halted_m[c], "R8 ack on exhausted channel", c, -1);
      check($onehot(ack), "R5 ack one-hot", int'(ack), 1 << c);
      if (order_phase) begin
        check(c > prev_ack, "R6 lowest first", c, prev_ack + 1);
        prev_ack = c;
      end
      if (!exp_dir[c]) check(dev_wdata == mem[exp_ptr[c]], "R2 output word", dev_wdata, mem[exp_ptr[c]]);
      else begin
        exp_mem[exp_ptr[c]] = data_for(c, moved[c]);
        exp_wr[exp_ptr[c]] = 1;
      end
      moved[c]++; pending[c]--; exp_ptr[c]++;
      if (exp_ptr[c] > exp_end[c]) expect_done[c] = 1;
    end
    for (int c = 0; c < NCH; c++) if (done[c]) begin
      check(expect_done[c], "R7 done timing", 1, int'(expect_done[c]));
      expect_done[c] = 0;
      halted_m[c] = !rearm_hit[c];
      rearm_hit[c] = 0;
    end
    if (mem_req && mem_we && mem_gnt && mem_addr >= 16 && mem_addr < 48) begin
      int c;
      c = (int'(mem_addr) - 16) / 2;
      check(mem_addr[0] == 0, "R3 write-back targets start word", mem_addr, mem_addr & ~1);
      check(mem_wdata == {exp_dir[c], 15'(exp_ptr[c])}, "R4 write-back value", mem_wdata,
            {exp_dir[c], 15'(exp_ptr[c])});
      if (c == co_ch && expect_done[c]) begin
        rearm_a[c] = 1;
        rearm_hit[c] = 1;
        co_ch = -1;
      end
    end
  end

  task automatic setup(int c, bit dir, int len);
    int b;
    b = 64 + 8 * c;
    mem[16 + 2*c] = {dir, 15'(b)};
    mem[17 + 2*c] = 16'(b + len - 1);
    exp_ptr[c] = b; exp_end[c] = b + len - 1; exp_dir[c] = dir; lens[c] = len;
    for (int i = 0; i < 8; i++) begin
      mem[b + i] = 16'($urandom);
      exp_wr[b + i] = 0;
    end
  endtask

  task automatic do_rearm(logic [NCH-1:0] m);
    @(negedge clk) rearm_t = m;
    for (int c = 0; c < NCH; c++) if (m[c]) halted_m[c] = 0;
    @(negedge clk) rearm_t = '0;
  endtask

  task automatic check_inputs();
    for (int a = 64; a < 192; a++) if (exp_wr[a]) begin
      check(mem[a] == exp_mem[a], "R2 input word in memory", mem[a], exp_mem[a]);
      exp_wr[a] = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin
      pending[c] = 0; moved[c] = 0; halted_m[c] = 0; expect_done[c] = 0; rearm_hit[c] = 0;
    end
    repeat (4) @(negedge clk);
    check(!mem_req, "R10 reset mem_req", mem_req, 0);
    check(ack == 0 && done == 0, "R10 reset ack/done", int'(ack | done), 0);
    rst_n = 1;
    mon_on = 1;

    // directed: all channels at once, ascending order, R1 descriptor layout
    for (int c = 0; c < NCH; c++) setup(c, c[0], 4);
    @(negedge clk);
    order_phase = 1;
    for (int c = 0; c < NCH; c++) pending[c] = 1;
    for (int w = 0; w < 3000; w++) begin
      @(negedge clk);
      if (ack == 0 && !mem_req && moved[NCH-1] == 1) break;
    end
    order_phase = 0;
    check(prev_ack == NCH - 1, "R6 all channels served", prev_ack, NCH - 1);
    for (int c = 0; c < NCH; c++)
      check(mem[16 + 2*c] == {c[0], 15'(64 + 8*c + 1)}, "R1 start word updated", mem[16 + 2*c],
            {c[0], 15'(64 + 8*c + 1)});
    check_inputs();

    // random rounds with over-requests
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < NCH; c++) begin
        setup(c, 1'($urandom), 1 + $urandom % 8);
        asked[c] = 0; moved[c] = 0; pending[c] = 0;
      end
      do_rearm('1);
      for (int t = 0; t < 600; t++) begin
        @(negedge clk);
        if ($urandom % 3 == 0) begin
          int c;
          c = $urandom % NCH;
          if (asked[c] < lens[c] + 2) begin asked[c]++; pending[c]++; end
        end
      end
      repeat (1500) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        int want;
        want = asked[c] < lens[c] ? asked[c] : lens[c];
        check(moved[c] == want, "R8 words moved vs range", moved[c], want);
        check(!expect_done[c], "R7 done seen", 1, 0);
        check(halted_m[c] == (asked[c] >= lens[c]), "R7 exhaustion", halted_m[c], asked[c] >= lens[c]);
        check(mem[16 + 2*c] == {exp_dir[c], 15'(exp_ptr[c])}, "R4 final start word",
              mem[16 + 2*c], {exp_dir[c], 15'(exp_ptr[c])});
        pending[c] = 0;
      end
      check_inputs();
    end

    // R9: rearm in the same cycle as the exhausting write-back
    force_gnt = 1;
    setup(5, 1'b0, 1);
    do_rearm(16'h0020);
    moved[5] = 0;
    co_ch = 5;
    @(negedge clk) pending[5] = 1;
    repeat (40) @(negedge clk);
    check(co_ch == -1, "R9 coincidence provoked", co_ch, -1);
    check(!halted_m[5], "R9 model eligible", halted_m[5], 0);
    setup(5, 1'b1, 1);
    @(negedge clk) pending[5] = 1;
    repeat (40) @(negedge clk);
    check(moved[5] == 2, "R9 served after coincident rearm", moved[5], 2);
    check_inputs();

    // contrast: no rearm -> ignored
    setup(5, 1'b1, 1);
    @(negedge clk) pending[5] = 1;
    repeat (40) @(negedge clk);
    check(moved[5] == 2, "R8 ignored without rearm", moved[5], 2);
    check(!mem_req, "R8 no memory cycle", mem_req, 0);
    finish_run();
  end
endmodule